// File: doc/BRIEF.md
# Paged buffer address pointer

This block generates byte addresses into a packet-buffer RAM that is divided into equal pages. The host loads a page number and an offset within that page through two registers. Each access the host makes to the buffer's data port then produces one address, together with a read or write strobe, for the RAM controller. A control register sets the direction of those accesses. It also decides whether the pointer advances after each access, and what happens when the offset runs off the end of a page.

The advance is one byte for an 8-bit host bus with word mode off. It is two bytes for an 8-bit bus with word mode on, and two bytes for a 16-bit bus. When the offset crosses the page boundary, the pointer can carry into the next page or fold back to the start of the same page. A configuration input selects 256-byte or 512-byte pages, and the page number is trimmed so that page and offset together fit the RAM address. To guard against a stray update, a new page number is accepted only after the offset register has been written. The configuration inputs are meant to be static while the buffer is in use.

Top module: `pbuf_addr_ptr`

## Requirements
- R1: After reset the page, the offset and all control bits are zero. The direction is write and auto-increment is off. `ctrl_rdata`, `pos_rdata`, `ram_addr`, `ram_rd` and `ram_wr` are all zero.
- R2: A register write with `reg_sel`=0 loads the control fields from `reg_wdata` bits 7 (direction, 1 = read), 6 (auto-increment) and 5 (carry mode, 1 = next page). `ctrl_rdata` returns these bits in the same positions and the page number in bits 4..0, with bits 15..8 always zero. `ctrl_rdata` always shows the register state as of the last clock edge.
- R3: A register write with `reg_sel`=1 loads the offset from `reg_wdata`, keeping 8 bits with 256-byte pages and 9 bits with 512-byte pages. `pos_rdata` shows the offset as of the last edge.
- R4: A control write changes the page field only if an offset write has occurred since the previous control write; otherwise the page is kept and only bits 7..5 change. Each offset write allows one page update.
- R5: A stored page number is masked to 5 bits when `cfg_pg_large`=0 (256-byte pages) and to 4 bits when `cfg_pg_large`=1 (512-byte pages).
- R6: A cycle with `data_stb` high is followed on the next cycle by a one-cycle pulse on `ram_rd` (direction 1) or on `ram_wr` (direction 0). In that cycle `ram_addr` equals page × page size + offset, using the values held before that edge. `ram_addr` holds between accesses.
- R7: With auto-increment off, an access leaves the offset and the page unchanged.
- R8: With auto-increment on, an access advances the offset by 1 when `cfg_bus16`=0 and `cfg_word_mode`=0, and by 2 otherwise.
- R9: When the advanced offset reaches the page size and carry mode is 1, the offset takes the low bits of the sum. The page becomes (page+1) masked, so the highest page wraps to page 0.
- R10: When the advanced offset reaches the page size and carry mode is 0, the offset takes the low bits of the sum and the page is unchanged.
- R11: A register write in the same cycle as an access takes effect after that access. The access uses the old direction, auto-increment, page and offset. An offset write replaces the advance entirely. An accepted page write replaces the carry increment, while an ignored page write leaves the carry increment in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bus16 | input | 1 | Host bus is 16 bits wide |
| cfg_word_mode | input | 1 | Word mode on an 8-bit bus |
| cfg_pg_large | input | 1 | 0: 256-byte pages, 1: 512-byte pages |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: control register, 1: offset register |
| reg_wdata | input | 16 | Register write data |
| data_stb | input | 1 | One completed data-port access |
| ctrl_rdata | output | 16 | Control and page readback |
| pos_rdata | output | 16 | Offset readback |
| ram_addr | output | 13 | RAM byte address of the last access |
| ram_rd | output | 1 | Read pulse for the RAM |
| ram_wr | output | 1 | Write pulse for the RAM |

## Verification
A data-port access and a host register write can land on the same clock edge. In that case the pointer advance and the register load compete for the same offset and page state. The bench provokes this with directed cycles in which a strobe coincides with an offset write, with an accepted page write at a page boundary, and with an ignored control write that flips the direction. A long pseudo-random run then mixes strobes and writes freely. Each cycle is judged against a behavioural model that applies the access first and the register write second, and the bench compares every output against that model on every clock.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  localparam int CTRL_DIR_BIT   = 7;
  localparam int CTRL_INC_BIT   = 6;
  localparam int CTRL_CARRY_BIT = 5;

  typedef struct packed {
    logic rd_dir;
    logic auto_inc;
    logic carry_pg;
  } ptr_ctrl_t;

  function automatic logic [1:0] step_size(input logic bus16, input logic word_mode);
    return (bus16 || word_mode) ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/pbuf_offset.sv
module pbuf_offset #(
  parameter int OFS_W_SM = 8,
  parameter int OFS_W_LG = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pg_large,
  input  logic                load,
  input  logic [OFS_W_LG-1:0] load_val,
  input  logic                adv,
  input  logic [1:0]          step,
  output logic [OFS_W_LG-1:0] ofs_q,
  output logic [OFS_W_LG-1:0] ofs_next,
  output logic                carry
);
  localparam logic [OFS_W_LG-1:0] MASK_SM = OFS_W_LG'((2**OFS_W_SM) - 1);

  logic [OFS_W_LG-1:0] ofs_mask;
  logic [OFS_W_LG:0]   sum;

  always_comb begin
    ofs_mask = pg_large ? '1 : MASK_SM;
    sum      = {1'b0, ofs_q} + {{(OFS_W_LG-1){1'b0}}, step};
    carry    = adv && (pg_large ? sum[OFS_W_LG] : sum[OFS_W_SM]);
    if (load)
      ofs_next = load_val & ofs_mask;
    else if (adv)
      ofs_next = sum[OFS_W_LG-1:0] & ofs_mask;
    else
      ofs_next = ofs_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ofs_q <= '0;
    else     ofs_q <= ofs_next;
  end

  // R8: an advance always moves the offset
  a_r8_moves: assert property (@(posedge clk) disable iff (rst)
    adv && !load |=> ofs_q != $past(ofs_q));

  // R3: offset loaded in small-page mode has no bits above the page width
  a_r3_masked: assert property (@(posedge clk) disable iff (rst)
    load && !pg_large |=> ofs_q[OFS_W_LG-1:OFS_W_SM] == '0);
endmodule

// File: rtl/pbuf_regs.sv
module pbuf_regs import pbuf_pkg::*; #(
  parameter int PAGE_FW = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_wr,
  input  logic               ofs_wr,
  input  logic [7:0]         wbyte,
  input  logic [PAGE_FW-1:0] page_mask,
  input  logic               carry_in,
  output ptr_ctrl_t          ctrl_q,
  output ptr_ctrl_t          ctrl_next,
  output logic [PAGE_FW-1:0] page_q,
  output logic [PAGE_FW-1:0] page_next
);
  logic armed_q;

  always_comb begin
    ctrl_next = ctrl_q;
    page_next = page_q;
    if (carry_in && ctrl_q.carry_pg)
      page_next = (page_q + PAGE_FW'(1)) & page_mask;
    if (ctrl_wr) begin
      ctrl_next.rd_dir   = wbyte[CTRL_DIR_BIT];
      ctrl_next.auto_inc = wbyte[CTRL_INC_BIT];
      ctrl_next.carry_pg = wbyte[CTRL_CARRY_BIT];
      if (armed_q)
        page_next = wbyte[PAGE_FW-1:0] & page_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      page_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_next;
      page_q <= page_next;
      if (ofs_wr)       armed_q <= 1'b1;
      else if (ctrl_wr) armed_q <= 1'b0;
    end
  end

  // R4: a control write without a prior offset write keeps the page
  a_r4_page_ignored: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && !armed_q && !carry_in |=> $stable(page_q));

  // R4: a control write consumes the permission
  a_r4_disarm: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> !armed_q);

  // R10: a fold-back overflow keeps the page
  a_r10_same_page: assert property (@(posedge clk) disable iff (rst)
    carry_in && !ctrl_q.carry_pg && !ctrl_wr |=> $stable(page_q));
endmodule

// File: rtl/pbuf_addr_ptr.sv
module pbuf_addr_ptr import pbuf_pkg::*; #(
  parameter int ADDR_W   = 13,
  parameter int OFS_W_SM = 8,
  parameter int OFS_W_LG = 9,
  parameter int PAGE_FW  = 5,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_bus16,
  input  logic              cfg_word_mode,
  input  logic              cfg_pg_large,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              data_stb,
  output logic [DATA_W-1:0] ctrl_rdata,
  output logic [DATA_W-1:0] pos_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_rd,
  output logic              ram_wr
);
  localparam int PG_W_SM = ADDR_W - OFS_W_SM;
  localparam int PG_W_LG = ADDR_W - OFS_W_LG;
  localparam logic [PAGE_FW-1:0] PMASK_SM = PAGE_FW'((2**PG_W_SM) - 1);
  localparam logic [PAGE_FW-1:0] PMASK_LG = PAGE_FW'((2**PG_W_LG) - 1);

  logic                ofs_wr, ctrl_wr, adv, carry;
  logic [1:0]          step;
  logic [PAGE_FW-1:0]  page_mask, page_q, page_next;
  logic [OFS_W_LG-1:0] ofs_q, ofs_next;
  logic [ADDR_W-1:0]   pg_ext, addr_now;
  ptr_ctrl_t           ctrl_q, ctrl_next;

  assign ofs_wr    = reg_wr && reg_sel;
  assign ctrl_wr   = reg_wr && !reg_sel;
  assign adv       = data_stb && ctrl_q.auto_inc && !ofs_wr;
  assign step      = step_size(cfg_bus16, cfg_word_mode);
  assign page_mask = cfg_pg_large ? PMASK_LG : PMASK_SM;

  pbuf_offset #(.OFS_W_SM(OFS_W_SM), .OFS_W_LG(OFS_W_LG)) u_ofs (
    .clk      (clk),
    .rst      (rst),
    .pg_large (cfg_pg_large),
    .load     (ofs_wr),
    .load_val (reg_wdata[OFS_W_LG-1:0]),
    .adv      (adv),
    .step     (step),
    .ofs_q    (ofs_q),
    .ofs_next (ofs_next),
    .carry    (carry)
  );

  pbuf_regs #(.PAGE_FW(PAGE_FW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .ofs_wr    (ofs_wr),
    .wbyte     (reg_wdata[7:0]),
    .page_mask (page_mask),
    .carry_in  (carry),
    .ctrl_q    (ctrl_q),
    .ctrl_next (ctrl_next),
    .page_q    (page_q),
    .page_next (page_next)
  );

  always_comb begin
    pg_ext = ADDR_W'(page_q & page_mask);
    if (cfg_pg_large)
      addr_now = (pg_ext << OFS_W_LG) | ADDR_W'(ofs_q);
    else
      addr_now = (pg_ext << OFS_W_SM) | ADDR_W'(ofs_q[OFS_W_SM-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr   <= '0;
      ram_rd     <= 1'b0;
      ram_wr     <= 1'b0;
      ctrl_rdata <= '0;
      pos_rdata  <= '0;
    end else begin
      ram_rd     <= data_stb && ctrl_q.rd_dir;
      ram_wr     <= data_stb && !ctrl_q.rd_dir;
      if (data_stb) ram_addr <= addr_now;
      ctrl_rdata <= DATA_W'({ctrl_next, page_next});
      pos_rdata  <= DATA_W'(ofs_next);
    end
  end

  // R6: every access yields exactly one strobe
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
    data_stb |=> (ram_rd != ram_wr));

  // R6: no strobe without an access
  a_r6_idle: assert property (@(posedge clk) disable iff (rst)
    !data_stb |=> !ram_rd && !ram_wr);

  // R6: address holds between accesses
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !data_stb |=> $stable(ram_addr));

  // R2: reserved readback bits stay zero
  a_r2_reserved: assert property (@(posedge clk) disable iff (rst)
    ctrl_rdata[DATA_W-1:8] == '0);
endmodule

// File: tb/sim_pbuf_addr_ptr.sv
module sim_pbuf_addr_ptr;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, cfg_bus16, cfg_word_mode, cfg_pg_large, reg_wr, reg_sel, data_stb;
  logic [15:0] reg_wdata, ctrl_rdata, pos_rdata;
  logic [12:0] ram_addr;
  logic        ram_rd, ram_wr;

  pbuf_addr_ptr u0 (
    .clk(clk), .rst(rst), .cfg_bus16(cfg_bus16), .cfg_word_mode(cfg_word_mode),
    .cfg_pg_large(cfg_pg_large), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .data_stb(data_stb), .ctrl_rdata(ctrl_rdata),
    .pos_rdata(pos_rdata), .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_wr(ram_wr)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    started = 0;
  int    m_page, m_ofs, m_dir, m_inc, m_carry, m_armed;
  int    e_addr, e_rd, e_wr, e_ctrl, e_pos;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference: access first, then register write
  always @(posedge clk) begin : model
    int psize, pmask, stp, s, np, no;
    started = 1;
    if (rst) begin
      m_page = 0; m_ofs = 0; m_dir = 0; m_inc = 0; m_carry = 0; m_armed = 0;
      e_addr = 0; e_rd = 0; e_wr = 0; e_ctrl = 0; e_pos = 0;
    end else begin
      psize = cfg_pg_large ? 512 : 256;
      pmask = cfg_pg_large ? 15 : 31;
      stp   = (cfg_bus16 || cfg_word_mode) ? 2 : 1;
      e_rd = 0; e_wr = 0;
      if (data_stb) begin
        e_addr = (m_page & pmask) * psize + (m_ofs % psize);
        e_rd = m_dir; e_wr = 1 - m_dir;
      end
      np = m_page; no = m_ofs;
      if (data_stb && m_inc == 1 && !(reg_wr && reg_sel)) begin
        s = m_ofs + stp;
        no = s % psize;
        if (s >= psize && m_carry == 1) np = (m_page + 1) & pmask;
      end
      if (reg_wr && reg_sel) begin
        no = int'(reg_wdata) % psize;
        m_armed = 1;
      end
      if (reg_wr && !reg_sel) begin
        if (m_armed == 1) np = int'(reg_wdata[4:0]) & pmask;
        m_armed = 0;
        m_dir = int'(reg_wdata[7]); m_inc = int'(reg_wdata[6]); m_carry = int'(reg_wdata[5]);
      end
      m_page = np; m_ofs = no;
      e_ctrl = m_dir * 128 + m_inc * 64 + m_carry * 32 + m_page;
      e_pos  = m_ofs;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check({cur_req, " ram_addr"}, int'(ram_addr), e_addr);
      check({cur_req, " ram_rd"}, int'(ram_rd), e_rd);
      check({cur_req, " ram_wr"}, int'(ram_wr), e_wr);
      check({cur_req, " ctrl_rdata"}, int'(ctrl_rdata), e_ctrl);
      check({cur_req, " pos_rdata"}, int'(pos_rdata), e_pos);
    end
  end

  task automatic tick(input bit stb, input bit wr, input bit sel, input int wd);
    data_stb = stb; reg_wr = wr; reg_sel = sel; reg_wdata = 16'(wd);
    @(negedge clk); #1;
    data_stb = 0; reg_wr = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit [15:0] x;
    rst = 1; cfg_bus16 = 0; cfg_word_mode = 0; cfg_pg_large = 0;
    reg_wr = 0; reg_sel = 0; data_stb = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 ctrl", int'(ctrl_rdata), 0);
    check("R1 pos", int'(pos_rdata), 0);
    check("R1 strobes", int'(ram_rd) + int'(ram_wr), 0);
    check("R1 addr", int'(ram_addr), 0);
    rst = 0;

    cur_req = "R2";
    tick(0, 1, 0, 'hFFE0);
    check("R2 ctrl fields", int'(ctrl_rdata), 'h00E0);
    cur_req = "R4";
    tick(0, 1, 0, 'h00E5);
    check("R4 page ignored", int'(ctrl_rdata), 'h00E0);
    cur_req = "R3";
    tick(0, 1, 1, 'h01FE);
    check("R3 offset masked", int'(pos_rdata), 'h00FE);
    cur_req = "R4";
    tick(0, 1, 0, 'h00E5);
    check("R4 page accepted", int'(ctrl_rdata), 'h00E5);
    tick(0, 1, 0, 'h00E7);
    check("R4 second page write ignored", int'(ctrl_rdata), 'h00E5);

    cur_req = "R6";
    tick(1, 0, 0, 0);
    check("R6 rd strobe", int'(ram_rd), 1);
    check("R6 addr", int'(ram_addr), 'h05FE);
    check("R8 step one", int'(pos_rdata), 'h00FF);
    cur_req = "R9";
    tick(1, 0, 0, 0);
    check("R9 addr", int'(ram_addr), 'h05FF);
    check("R9 next page", int'(ctrl_rdata), 'h00E6);
    check("R9 offset start", int'(pos_rdata), 0);
    cur_req = "R8";
    cfg_word_mode = 1;
    tick(1, 0, 0, 0);
    check("R8 word step", int'(pos_rdata), 2);
    check("R8 addr", int'(ram_addr), 'h0600);
    cfg_word_mode = 0; cfg_bus16 = 1;
    tick(1, 0, 0, 0);
    check("R8 bus16 step", int'(pos_rdata), 4);
    cfg_bus16 = 0;

    cur_req = "R10";
    tick(0, 1, 1, 'h00FE);
    tick(0, 1, 0, 'h0046);
    check("R10 ctrl", int'(ctrl_rdata), 'h0046);
    cfg_word_mode = 1;
    tick(1, 0, 0, 0);
    check("R10 wr strobe", int'(ram_wr), 1);
    check("R10 addr", int'(ram_addr), 'h06FE);
    check("R10 same page", int'(ctrl_rdata), 'h0046);
    check("R10 offset start", int'(pos_rdata), 0);
    cfg_word_mode = 0;

    cur_req = "R9";
    tick(0, 1, 1, 'h00FF);
    tick(0, 1, 0, 'h007F);
    check("R9 top page", int'(ctrl_rdata), 'h007F);
    tick(1, 0, 0, 0);
    check("R9 addr top", int'(ram_addr), 'h1FFF);
    check("R9 page wraps to zero", int'(ctrl_rdata), 'h0060);

    cur_req = "R5";
    cfg_pg_large = 1;
    tick(0, 1, 1, 'h01FF);
    check("R3 large offset", int'(pos_rdata), 'h01FF);
    tick(0, 1, 0, 'h007F);
    check("R5 page masked", int'(ctrl_rdata), 'h006F);
    tick(1, 0, 0, 0);
    check("R5 large addr", int'(ram_addr), 'h1FFF);
    check("R5 large wrap", int'(ctrl_rdata), 'h0060);

    cur_req = "R7";
    tick(0, 1, 0, 'h0080);
    check("R7 ctrl", int'(ctrl_rdata), 'h0080);
    tick(1, 0, 0, 0);
    tick(1, 0, 0, 0);
    check("R7 offset held", int'(pos_rdata), 0);
    check("R7 addr", int'(ram_addr), 0);
    check("R7 rd strobe", int'(ram_rd), 1);

    cur_req = "R11";
    cfg_pg_large = 0;
    tick(0, 1, 1, 'h0010);
    tick(0, 1, 0, 'h00E3);
    tick(1, 1, 1, 'h0040);
    check("R11 addr before load", int'(ram_addr), 'h0310);
    check("R11 offset write wins", int'(pos_rdata), 'h0040);
    tick(0, 1, 1, 'h00FF);
    tick(1, 1, 0, 'h0069);
    check("R11 old direction", int'(ram_rd), 1);
    check("R11 addr", int'(ram_addr), 'h03FF);
    check("R11 page write wins", int'(ctrl_rdata), 'h0069);
    check("R11 offset advanced", int'(pos_rdata), 0);
    tick(1, 1, 0, 'h00E9);
    check("R11 old dir write", int'(ram_wr), 1);
    check("R11 addr2", int'(ram_addr), 'h0900);
    check("R11 old inc", int'(pos_rdata), 1);
    check("R11 ctrl", int'(ctrl_rdata), 'h00E9);

    cur_req = "R8 R9 R10 R11 mixed";
    x = 16'hACE1;
    for (int i = 0; i < 800; i++) begin
      x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
      if (i == 400) cfg_pg_large = 1;
      cfg_bus16 = x[12] & x[2];
      cfg_word_mode = x[14];
      tick(x[0], x[3] & x[5], x[7], int'({x[8:1], x[15:8]}));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule